// File: doc/BRIEF.md
# Exception State Register Unit

This unit holds the privileged exception state of a small 32-bit RISC core. When control raises an exception strobe, the unit records the address of the offending instruction, the reason code and, for address faults, the faulting data address. It also pushes the status mode/enable stack so that the handler runs in kernel mode with interrupts off. It presents a fixed handler entry address, which the core loads into its PC.

A return-from-exception strobe pops the mode/enable stack. Five hardware interrupt lines are registered into pending bits of the cause register. A single request output tells control that an enabled, unmasked interrupt is waiting. Software reads and writes the four registers through a simple select/write-enable port.

Top module: `exc_regs`

## Requirements
- R1: After reset, all four registers read zero and `irq_req` is 0.
- R2: `handler_pc` is always 0x8000_0080.
- R3: On an exception strobe, status bits 5:0 take the value of their former bits 3:0 in bits 5:2, and bits 1:0 become 0. Each pair is {bit1 = user mode when 1, bit0 = interrupt enable}, with the current pair at bits 1:0, previous at 3:2 and old at 5:4.
- R4: On an exception strobe, EPC takes `exc_pc`, or `exc_pc` minus 4 when `exc_pc_adv` is 1.
- R5: On an exception strobe, cause bits 5:2 take `exc_code`. The bad-address register takes `exc_addr` only when the code is 4 or 5, and otherwise keeps its value.
- R6: On a return strobe without an exception, status bits 3:0 take the former bits 5:2, and bits 5:4 keep their value.
- R7: Cause bits 14:10 show `hw_irq[4:0]` as sampled at the previous clock edge, whatever the enable and mask. Cause bit 15 reads 0, and register writes never change bits 14:10.
- R8: `irq_req` is 1 exactly when status bit 0 is 1 and the pending bits ANDed with status bits 12:8 are nonzero. Level i is masked by status bit 8+i.
- R9: An exception strobe overrides a return strobe and a register write in the same cycle, and those have no effect. A return strobe overrides a register write.
- R10: The register port uses `reg_sel` 0 for EPC, 1 for cause, 2 for bad address and 3 for status. In status, only bits 15:8 and 5:0 are stored, and bits 7:6 read 0. In cause, only bits 5:2 are writable. Unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_take | input | 1 | Exception strobe |
| exc_code | input | 4 | Reason code for the exception |
| exc_pc | input | 32 | PC associated with the exception |
| exc_pc_adv | input | 1 | PC has already been advanced by 4 |
| exc_addr | input | 32 | Faulting memory address |
| hw_irq | input | 5 | Hardware interrupt request lines |
| eret | input | 1 | Return-from-exception strobe |
| reg_sel | input | 2 | Register select |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| handler_pc | output | 32 | Exception handler entry address |
| irq_req | output | 1 | Enabled interrupt pending |

## Verification
The assertions assume that `hw_irq` holds 0 during reset and that every input is a known value at each clock edge once reset ends. The bench drives all inputs on the falling edge, holds the interrupt lines low through reset, and draws exception codes only from the defined reason list. Strobes and writes are drawn independently, so exception/return/write collisions occur often and the priority properties are exercised.

// File: rtl/exc_regs.sv
module exc_regs #(
  parameter logic [31:0] HANDLER_ADDR = 32'h8000_0080
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        exc_take,
  input  logic [3:0]  exc_code,
  input  logic [31:0] exc_pc,
  input  logic        exc_pc_adv,
  input  logic [31:0] exc_addr,
  input  logic [4:0]  hw_irq,
  input  logic        eret,
  input  logic [1:0]  reg_sel,
  input  logic        reg_we,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic [31:0] handler_pc,
  output logic        irq_req
);

  logic [31:0] epc_q, bad_q;
  logic [3:0]  code_q;
  logic [4:0]  pend_q;
  logic [7:0]  mask_q;
  logic [5:0]  stk_q;

  wire addr_fault = (exc_code == 4'd4) || (exc_code == 4'd5);
  wire [31:0] cause_rd  = {16'b0, 1'b0, pend_q, 4'b0, code_q, 2'b0};
  wire [31:0] status_rd = {16'b0, mask_q, 2'b0, stk_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc_q  <= '0;
      bad_q  <= '0;
      code_q <= '0;
      pend_q <= '0;
      mask_q <= '0;
      stk_q  <= '0;
    end else begin
      pend_q <= hw_irq;
      if (exc_take) begin
        epc_q  <= exc_pc_adv ? exc_pc - 32'd4 : exc_pc;
        code_q <= exc_code;
        if (addr_fault) bad_q <= exc_addr;
        stk_q  <= {stk_q[3:0], 2'b00};
      end else if (eret) begin
        stk_q  <= {stk_q[5:4], stk_q[5:2]};
      end else if (reg_we) begin
        case (reg_sel)
          2'd0: epc_q  <= reg_wdata;
          2'd1: code_q <= reg_wdata[5:2];
          2'd2: bad_q  <= reg_wdata;
          default: begin
            mask_q <= reg_wdata[15:8];
            stk_q  <= reg_wdata[5:0];
          end
        endcase
      end
    end
  end

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = epc_q;
      2'd1:    reg_rdata = cause_rd;
      2'd2:    reg_rdata = bad_q;
      default: reg_rdata = status_rd;
    endcase
  end

  assign handler_pc = HANDLER_ADDR;
  assign irq_req    = stk_q[0] && |(pend_q & mask_q[4:0]);

endmodule

module exc_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        exc_take,
  input logic [3:0]  exc_code,
  input logic [31:0] exc_pc,
  input logic        exc_pc_adv,
  input logic [31:0] exc_addr,
  input logic [4:0]  hw_irq,
  input logic        eret,
  input logic        reg_we,
  input logic [31:0] epc_q,
  input logic [31:0] bad_q,
  input logic [3:0]  code_q,
  input logic [4:0]  pend_q,
  input logic [5:0]  stk_q,
  input logic        irq_req
);

  a_r3_stack_push: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> (stk_q[1:0] == 2'b00) && (stk_q[5:2] == $past(stk_q[3:0])));

  a_r4_epc_capture: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> epc_q == ($past(exc_pc_adv) ? $past(exc_pc) - 32'd4 : $past(exc_pc)));

  a_r5_code_capture: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> code_q == $past(exc_code));

  a_r5_bad_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && (exc_code == 4'd4 || exc_code == 4'd5)) |=> bad_q == $past(exc_addr));

  a_r5_bad_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && exc_code != 4'd4 && exc_code != 4'd5) |=> $stable(bad_q));

  a_r6_stack_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (eret && !exc_take) |=> (stk_q[5:4] == $past(stk_q[5:4])) && (stk_q[3:0] == $past(stk_q[5:2])));

  a_r7_pending: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> pend_q == $past(hw_irq));

  a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> stk_q[0] && (pend_q != 5'd0));

  a_r9_eret_beats_write: assert property (@(posedge clk) disable iff (!rst_n)
    (eret && !exc_take && reg_we) |=> $stable(epc_q) && $stable(bad_q) && $stable(code_q));

endmodule

bind exc_regs exc_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .exc_take(exc_take), .exc_code(exc_code),
  .exc_pc(exc_pc), .exc_pc_adv(exc_pc_adv), .exc_addr(exc_addr),
  .hw_irq(hw_irq), .eret(eret), .reg_we(reg_we), .epc_q(epc_q),
  .bad_q(bad_q), .code_q(code_q), .pend_q(pend_q), .stk_q(stk_q),
  .irq_req(irq_req)
);

// File: tb/exc_regs_tb_top.sv
`timescale 1ns/1ps
module exc_regs_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        exc_take = 0, exc_pc_adv = 0, eret = 0, reg_we = 0;
  logic [3:0]  exc_code = 0;
  logic [31:0] exc_pc = 0, exc_addr = 0, reg_wdata = 0;
  logic [4:0]  hw_irq = 0;
  logic [1:0]  reg_sel = 0;
  logic [31:0] reg_rdata, handler_pc;
  logic        irq_req;

  int total = 0, bad = 0;
  bit done = 0;

  logic [31:0] m_epc = 0, m_bad = 0;
  logic [3:0]  m_code = 0;
  logic [4:0]  m_pend = 0;
  logic [7:0]  m_mask = 0;
  logic [5:0]  m_stk = 0;

  exc_regs dut_i (.*);

  always #4 clk = ~clk;

  function automatic logic [31:0] exp_rd(input logic [1:0] s);
    case (s)
      2'd0: return m_epc;
      2'd1: return {16'b0, 1'b0, m_pend, 4'b0, m_code, 2'b0};
      2'd2: return m_bad;
      default: return {16'b0, m_mask, 2'b0, m_stk};
    endcase
  endfunction

  function automatic logic exp_irq();
    return m_stk[0] && |(m_pend & m_mask[4:0]);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int s = 0; s < 4; s++) begin
      reg_sel = s[1:0];
      #0.5;
      chk($sformatf("%s sel%0d", tag, s), reg_rdata, exp_rd(s[1:0]));
    end
    chk({tag, " R8 irq"}, {31'b0, irq_req}, {31'b0, exp_irq()});
    chk({tag, " R2 handler"}, handler_pc, 32'h8000_0080);
  endtask

  task automatic step(input logic e, input logic [3:0] code, input logic [31:0] pc,
                      input logic adv, input logic [31:0] addr, input logic [4:0] irq,
                      input logic r, input logic we, input logic [1:0] sel,
                      input logic [31:0] wd, input string tag);
    @(negedge clk);
    exc_take = e; exc_code = code; exc_pc = pc; exc_pc_adv = adv; exc_addr = addr;
    hw_irq = irq; eret = r; reg_we = we; reg_sel = sel; reg_wdata = wd;
    @(posedge clk);
    m_pend = irq;
    if (e) begin
      m_epc = adv ? pc - 32'd4 : pc;
      m_code = code;
      if (code == 4'd4 || code == 4'd5) m_bad = addr;
      m_stk = {m_stk[3:0], 2'b00};
    end else if (r) begin
      m_stk = {m_stk[5:4], m_stk[5:2]};
    end else if (we) begin
      case (sel)
        2'd0: m_epc = wd;
        2'd1: m_code = wd[5:2];
        2'd2: m_bad = wd;
        default: begin m_mask = wd[15:8]; m_stk = wd[5:0]; end
      endcase
    end
    #1;
    exc_take = 0; eret = 0; reg_we = 0;
    check_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] codes [9];
    codes = '{4'd0, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9, 4'd10, 4'd12};
    void'($urandom(32'd4021));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all("R1 reset");
    rst_n = 1;

    step(0,0,0,0,0,5'd0,0,1,2'd3,32'h0000_FF03,"R10 status write");
    step(0,0,0,0,0,5'b00100,0,0,2'd0,0,"R7 pending level2");
    step(0,0,0,0,0,5'b00100,0,0,2'd0,0,"R8 irq enabled");
    step(0,0,0,0,0,5'b00100,0,1,2'd3,32'h0000_FB03,"R8 level2 masked");
    step(0,0,0,0,0,5'b00100,0,1,2'd3,32'hFFFF_FFFF,"R10 status reserved bits");
    step(1,4'd12,32'h0000_0400,1,32'h1234_5678,5'b00100,0,0,2'd0,0,"R3 R4 exc adv");
    step(0,0,0,0,0,5'b00100,1,0,2'd0,0,"R6 eret pop");
    step(1,4'd4,32'h0000_0800,0,32'hDEAD_BEE0,5'b0,0,0,2'd0,0,"R5 addr fault");
    step(1,4'd8,32'h0000_0900,0,32'h1111_1111,5'b0,0,0,2'd0,0,"R5 syscall keeps bad");
    step(1,4'd5,32'h0000_0A04,1,32'h2222_2222,5'b0,0,1,2'd0,32'hCAFE_0000,"R9 exc beats write");
    step(0,0,0,0,0,5'b0,1,1,2'd2,32'hCAFE_0001,"R9 eret beats write");
    step(0,0,0,0,0,5'b11111,0,1,2'd1,32'hFFFF_FFFF,"R7 pending not writable");
    step(0,0,0,0,0,5'b00000,0,0,2'd0,0,"R7 pending clears");

    for (int i = 0; i < 600; i++) begin
      logic [31:0] rnd;
      rnd = $urandom;
      step(rnd[2:0] == 3'd0, codes[$urandom_range(8,0)], $urandom & 32'hFFFF_FFFC,
           rnd[3], $urandom, $urandom, rnd[6:4] == 3'd0, rnd[7],
           rnd[9:8], $urandom, "R3 R4 R5 R6 R7 R8 R9 R10 random");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule